// File: doc/BRIEF.md
# Direct-Sampling Digital Down Converter

This block sits between a 12-bit sampling converter running at one fifth of the system clock and an audio-rate output path. It multiplies each RF sample by a cosine from a numerically controlled oscillator, then integrates, decimates and lightly equalizes the in-phase product. The result is a 12-bit baseband stream at about 48 kHz, about 22 kHz wide, which suits an analog audio link. A carrier selected by the tuning word lands at zero frequency. The sum-frequency image is rejected by the decimating low-pass chain.

The tuning word sets the oscillator step per input sample. The increment is 2^27 × f_carrier / f_sample. A new word takes effect on the next sample strobe and continues from the current phase, so retuning never causes a phase jump. Only the cosine (in-phase) path exists.

Top module: `rf_ddc`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `bb_valid` is 0 and `bb_sample` is 0.
- R2: An internal sample strobe fires every 5 system clocks. Its first effective edge is the fifth rising clock edge after reset is released. `adc_sample` and `tune_word` are used only on strobe edges.
- R3: The 27-bit phase accumulator starts at 0 after reset. It advances by `tune_word` (modulo 2^27) on each strobe edge and holds otherwise. A change of `tune_word` never resets the phase.
- R4: The oscillator value is +2047 at phase 0 and -2047 at phase 2^26 (half a cycle). It never takes the value -2048.
- R5: The mixer product is floor(x × c / 2048), where x is the signed input and c the oscillator value.
- R6: `bb_valid` is a single-cycle pulse. It repeats every 208 strobes, which is every 1040 system clocks.
- R7: With `tune_word` = 0 and a constant input x, the settled output equals floor(m × 208^3 / 2^24), where m = floor(x × 2047 / 2048).
- R8: With `tune_word` = 2^26 the product alternates in sign on every sample, and the settled output magnitude is at most 1.
- R9: The output is saturated to the signed 12-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sample | input | 12 | Signed two's complement RF sample; mid-scale is 0 |
| tune_word | input | 27 | Oscillator phase increment per input sample |
| bb_sample | output | 12 | Signed in-phase baseband sample |
| bb_valid | output | 1 | One-cycle strobe marking a new `bb_sample` |

## Verification
A corrupted phase accumulator or folding error shows up at the output as a wrong sign or magnitude of the settled DC level. This appears within about seven output periods, because the integrators need three windows to fill. A phase reset on retune flips the sign of the frozen result, so it is visible as soon as the chain settles. A decimation counter fault shows up at once in the spacing of `bb_valid`, and integrator width or wrap faults corrupt the very first settled output.

// File: rtl/rf_ddc_pkg.sv
package rf_ddc_pkg;

    localparam int SMP_W       = 12;
    localparam int ACC_W       = 27;
    localparam int LUT_AW      = 8;
    localparam int CLK_PER_SMP = 5;
    localparam int DECIM       = 208;
    localparam int CIC_N       = 3;
    localparam int GROWTH      = $clog2(DECIM ** CIC_N);

    typedef logic signed [SMP_W-1:0] sample_t;

    // Oscillator table address: quadrant bits above the quarter-wave index
    typedef struct packed {
        logic [1:0]        quad;
        logic [LUT_AW-1:0] idx;
    } lut_addr_t;

    // Quarter-wave entry, offset by half a step so no entry sits on an axis
    function automatic int cos_entry(int i, int aw, int amp);
        real step;
        real a;
        step = 3.14159265358979 / (2.0 * real'(2 ** aw));
        a = real'(amp) * $cos((real'(i) + 0.5) * step);
        return $rtoi(a + 0.5);
    endfunction

endpackage

// File: rtl/rf_ddc_nco.sv
module rf_ddc_nco
    import rf_ddc_pkg::*;
#(
    parameter int ACC_BITS  = ACC_W,
    parameter int ADDR_BITS = LUT_AW,
    parameter int OUT_BITS  = SMP_W,
    parameter int DIV       = CLK_PER_SMP
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ACC_BITS-1:0]        tune,
    output logic                       tick,
    output logic [ACC_BITS-1:0]        phase,
    output logic signed [OUT_BITS-1:0] cos_val
);
    localparam int CNT_W   = $clog2(DIV);
    localparam int ENTRIES = 2 ** ADDR_BITS;
    localparam int AMP     = 2 ** (OUT_BITS - 1) - 1;

    logic [CNT_W-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (div_cnt == CNT_W'(DIV - 1)) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick = (div_cnt == CNT_W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (tick) begin
            phase <= phase + tune;
        end
    end

    logic signed [OUT_BITS-1:0] table_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
        localparam int VAL = cos_entry(g, ADDR_BITS, AMP);
        assign table_q[g] = OUT_BITS'(VAL);
    end

    logic [ADDR_BITS+1:0]       addr_bits;
    logic [1:0]                 quad;
    logic [ADDR_BITS-1:0]       idx;
    logic [ADDR_BITS-1:0]       idx_fold;
    logic signed [OUT_BITS-1:0] mag;

    assign addr_bits = phase[ACC_BITS-1 -: ADDR_BITS+2];
    assign quad      = addr_bits[ADDR_BITS+1 -: 2];
    assign idx       = addr_bits[ADDR_BITS-1:0];
    assign idx_fold  = quad[0] ? ~idx : idx;
    assign mag       = table_q[idx_fold];
    assign cos_val   = (quad[1] ^ quad[0]) ? -mag : mag;

endmodule

// File: rtl/rf_ddc_cic.sv
module rf_ddc_cic
    import rf_ddc_pkg::*;
#(
    parameter int IN_W  = SMP_W,
    parameter int OUT_W = SMP_W,
    parameter int R     = DECIM,
    parameter int N     = CIC_N,
    parameter int G     = GROWTH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic signed [IN_W-1:0]  in_val,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_val
);
    localparam int W      = IN_W + G;
    localparam int DCNT_W = $clog2(R);
    localparam int CW     = IN_W + 8;
    localparam logic signed [CW-1:0] MAXV = CW'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [CW-1:0] MINV = -CW'(2 ** (OUT_W - 1));

    logic signed [W-1:0] integ [N];
    logic signed [W-1:0] in_ext;

    assign in_ext = W'(in_val);

    for (genvar s = 0; s < N; s++) begin : g_int
        always_ff @(posedge clk) begin
            if (rst) begin
                integ[s] <= '0;
            end else if (in_vld) begin
                if (s == 0) integ[s] <= integ[s] + in_ext;
                else        integ[s] <= integ[s] + integ[(s == 0) ? 0 : s-1];
            end
        end
    end

    logic [DCNT_W-1:0] dcnt;
    logic              dump;

    assign dump = in_vld && (dcnt == DCNT_W'(R - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt <= '0;
        end else if (in_vld) begin
            dcnt <= dump ? '0 : dcnt + 1'b1;
        end
    end

    logic signed [W-1:0] cstage [N+1];
    logic signed [W-1:0] cdly   [N];

    assign cstage[0] = integ[N-1];

    for (genvar s = 0; s < N; s++) begin : g_comb
        assign cstage[s+1] = cstage[s] - cdly[s];
        always_ff @(posedge clk) begin
            if (rst)       cdly[s] <= '0;
            else if (dump) cdly[s] <= cstage[s];
        end
    end

    logic signed [W-1:0]  scaled_full;
    logic signed [CW-1:0] v;
    logic signed [CW-1:0] z1;
    logic signed [CW-1:0] z2;
    logic signed [CW-1:0] csum;
    logic signed [CW-1:0] ceq;
    logic signed [CW-1:0] sat;

    assign scaled_full = cstage[N] >>> G;
    assign v           = scaled_full[CW-1:0];
    // Equalizer taps -1/16, 18/16, -1/16: unit DC gain, slight high lift
    assign csum        = (z1 <<< 4) + (z1 <<< 1) - v - z2;
    assign ceq         = csum >>> 4;

    always_comb begin
        if (ceq > MAXV)      sat = MAXV;
        else if (ceq < MINV) sat = MINV;
        else                 sat = ceq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            z1      <= '0;
            z2      <= '0;
            out_vld <= 1'b0;
            out_val <= '0;
        end else begin
            out_vld <= dump;
            if (dump) begin
                z1      <= v;
                z2      <= z1;
                out_val <= sat[OUT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rf_ddc.sv
module rf_ddc
    import rf_ddc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] adc_sample,
    input  logic [ACC_W-1:0]        tune_word,
    output logic signed [SMP_W-1:0] bb_sample,
    output logic                    bb_valid
);
    localparam int PROD_W = 2 * SMP_W;

    logic                 nco_tick;
    logic [ACC_W-1:0]     nco_phase;
    sample_t              nco_cos;

    rf_ddc_nco #(
        .ACC_BITS (ACC_W),
        .ADDR_BITS(LUT_AW),
        .OUT_BITS (SMP_W),
        .DIV      (CLK_PER_SMP)
    ) nco_i (
        .clk    (clk),
        .rst    (rst),
        .tune   (tune_word),
        .tick   (nco_tick),
        .phase  (nco_phase),
        .cos_val(nco_cos)
    );

    logic signed [PROD_W-1:0] full_prod;
    logic signed [PROD_W-1:0] prod_shift;
    sample_t                  mix_q;
    logic                     mix_vld;

    assign full_prod  = adc_sample * nco_cos;
    assign prod_shift = full_prod >>> (SMP_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mix_q   <= '0;
            mix_vld <= 1'b0;
        end else begin
            mix_vld <= nco_tick;
            if (nco_tick) mix_q <= prod_shift[SMP_W-1:0];
        end
    end

    rf_ddc_cic #(
        .IN_W (SMP_W),
        .OUT_W(SMP_W),
        .R    (DECIM),
        .N    (CIC_N),
        .G    (GROWTH)
    ) cic_i (
        .clk    (clk),
        .rst    (rst),
        .in_vld (mix_vld),
        .in_val (mix_q),
        .out_vld(bb_valid),
        .out_val(bb_sample)
    );

endmodule

// File: rtl/rf_ddc_chk.sv
module rf_ddc_chk
    import rf_ddc_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input logic [ACC_W-1:0]        phase,
    input logic signed [SMP_W-1:0] cos_val,
    input logic signed [SMP_W-1:0] bb_sample,
    input logic                    bb_valid
);
    localparam int PERIOD = DECIM * CLK_PER_SMP;

    logic [31:0] gap;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (bb_valid) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != 32'hFFFF_FFFF) begin
            gap <= gap + 1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bb_valid && bb_sample == '0));

    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase));

    p_cos_range_r4: assert property (@(posedge clk) disable iff (rst)
        cos_val != -SMP_W'(2 ** (SMP_W - 1)));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        bb_valid |=> !bb_valid);

    p_out_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (bb_valid && seen) |-> (gap == 32'(PERIOD - 1)));

endmodule

bind rf_ddc rf_ddc_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (nco_tick),
    .phase    (nco_phase),
    .cos_val  (nco_cos),
    .bb_sample(bb_sample),
    .bb_valid (bb_valid)
);

// File: tb/rf_ddc_tb_top.sv
module rf_ddc_tb_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [11:0] adc_sample = '0;
    logic [26:0]        tune_word = '0;
    logic signed [11:0] bb_sample;
    logic               bb_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rf_ddc dut_i (
        .clk       (clk),
        .rst       (rst),
        .adc_sample(adc_sample),
        .tune_word (tune_word),
        .bb_sample (bb_sample),
        .bb_valid  (bb_valid)
    );

    task automatic check(string req, int act, int exp_v, bit ok);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Product per R5, settled DC per R7
    function automatic int mix_val(int x, int c);
        longint p;
        p = longint'(x) * longint'(c);
        return int'(p >>> 11);
    endfunction

    function automatic int dc_out(int m);
        longint d3;
        d3 = 64'd208 * 64'd208 * 64'd208;
        return int'((longint'(m) * d3) >>> 24);
    endfunction

    task automatic apply_reset(int x, int tw);
        @(negedge clk);
        rst = 1'b1;
        adc_sample = 12'(x);
        tune_word = 27'(tw);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_out();
        @(negedge clk);
        while (!bb_valid) @(negedge clk);
    endtask

    task automatic skip_outs(int n);
        for (int i = 0; i < n; i++) wait_out();
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid in reset", int'(bb_valid), 0, bb_valid == 1'b0);
        check("R1 sample in reset", int'(bb_sample), 0, bb_sample == 12'sd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after release", int'(bb_valid), 0, bb_valid == 1'b0);
    endtask

    task automatic t_dc(int x);
        int e;
        e = dc_out(mix_val(x, 2047));
        apply_reset(x, 0);
        skip_outs(7);
        for (int i = 0; i < 2; i++) begin
            wait_out();
            check("R7 R5 R4 settled DC", int'(bb_sample), e, int'(bb_sample) == e);
        end
    endtask

    task automatic t_spacing();
        int cyc;
        apply_reset(300, 0);
        wait_out();
        for (int i = 0; i < 3; i++) begin
            cyc = 0;
            @(negedge clk);
            check("R6 pulse width", int'(bb_valid), 0, bb_valid == 1'b0);
            cyc = 1;
            while (!bb_valid) begin
                @(negedge clk);
                cyc++;
            end
            check("R6 output spacing", cyc, 1040, cyc == 1040);
        end
    endtask

    task automatic t_image();
        apply_reset(1000, 27'h400_0000);
        skip_outs(7);
        for (int i = 0; i < 2; i++) begin
            wait_out();
            check("R8 R4 image rejected", int'(bb_sample), 0,
                  int'(bb_sample) <= 1 && int'(bb_sample) >= -1);
        end
    endtask

    // One strobe at a half-cycle step, then zero: phase must stay at half cycle
    task automatic t_retune();
        int e;
        e = dc_out(mix_val(1000, -2047));
        apply_reset(1000, 27'h400_0000);
        repeat (5) @(posedge clk);
        @(negedge clk);
        tune_word = '0;
        skip_outs(7);
        for (int i = 0; i < 2; i++) begin
            wait_out();
            check("R3 R2 phase kept on retune", int'(bb_sample), e, int'(bb_sample) == e);
        end
    endtask

    task automatic t_saturate_bound();
        apply_reset(2047, 0);
        skip_outs(8);
        wait_out();
        check("R9 output within range", int'(bb_sample), dc_out(mix_val(2047, 2047)),
              int'(bb_sample) == dc_out(mix_val(2047, 2047)));
    endtask

    initial begin
        t_reset();
        t_dc(1000);
        t_dc(-2048);
        t_dc(7);
        t_spacing();
        t_image();
        t_retune();
        t_saturate_bound();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule